// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block recovers one low-speed USB packet from the raw D+ and D- wires. It runs on a clock several times faster than the bit rate. Both wires first pass through a two-flop synchronizer. While the bus idles in J, the receiver waits for a J-to-K transition. It then hunts through the sync field, re-centring its bit timer on every J-to-K transition, until two K bits in a row confirm the end of sync. From then on it samples once per bit slot on a fixed fractional schedule and undoes the NRZI coding. It drops the bits inserted by bit stuffing and shifts the remaining bits into bytes, LSb first.

Each finished byte comes out as a one-cycle write strobe with an address and data, ready for an external buffer of `BUF_BYTES` entries. A single-ended zero seen in a bit slot ends the packet and raises a done pulse. A byte that would not fit in the buffer aborts the packet with an overflow pulse. A sync hunt that goes quiet for too long gives up with a sync-error pulse. The receiver does not check PIDs or CRCs and does not handle transactions.

Top module: `usb_ls_rx`

## Requirements
- R1: Line states are decoded from {dp_in, dm_in} as J = 01, K = 10 and SE0 = 00. After reset, and while the bus stays J, wr_en, pkt_done, overflow and sync_err stay low and byte_cnt reads 0.
- R2: A J-to-K transition starts the sync hunt. Every further J-to-K transition during the hunt re-centres the bit timer. Sync is confirmed only when two consecutive sampled bit slots are both K, so any number of leading K,J pairs before the closing K,K is accepted.
- R3: Each data bit is decoded as 1 when its line level equals the previous slot's level and as 0 when it differs. The first data bit is compared with the final sync K. Bits fill wr_data LSb first.
- R4: After six consecutive decoded 1s, the next bit slot is discarded and the run of ones restarts from zero. The run counter never exceeds six.
- R5: SE0 sampled in a data bit slot ends the packet with a one-cycle pkt_done. byte_cnt then equals the number of complete bytes, and trailing bits that do not fill a byte produce no write. At most one of pkt_done, overflow and sync_err is high in any cycle.
- R6: A byte that completes when BUF_BYTES bytes are already written is not written. overflow pulses once, pkt_done is not raised, and line activity is ignored until SE0 returns the receiver to idle.
- R7: If SYNC_TMO_BITS*CLK_NUM/CLK_DEN clocks pass after the last J-to-K transition of a hunt without sync being confirmed, sync_err pulses for one cycle, nothing is written, and the receiver returns to idle.
- R8: The first sample falls CLK_NUM/(2*CLK_DEN) clocks after the synchronized edge. Each later sample comes CLK_NUM/CLK_DEN clocks (rounded down) after the previous one, plus one clock whenever the accumulated remainder reaches CLK_DEN. Packets whose bit k starts floor(k*CLK_NUM/CLK_DEN) clocks after the first sync K are received without error.
- R9: Write addresses start at 0 in each packet and rise by one per byte. byte_cnt equals wr_addr+1 in each write cycle, changes only on a write or when cleared to 0 at sync confirmation, and holds its value after the packet ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_in | input | 1 | Raw D+ wire level |
| dm_in | input | 1 | Raw D- wire level |
| wr_en | output | 1 | One-cycle strobe per received byte |
| wr_addr | output | ADDR_W | Buffer index of the byte being written |
| wr_data | output | 8 | Received byte |
| byte_cnt | output | CNT_W | Bytes written in the current or last packet |
| pkt_done | output | 1 | One-cycle pulse on end of packet |
| overflow | output | 1 | One-cycle pulse when a byte does not fit |
| sync_err | output | 1 | One-cycle pulse when the sync hunt times out |

## Verification
A fault in the bit timer or in the stuffing run counter appears at the ports within one byte. wr_data is wrong, or gains or loses a bit, by the eighth slot after the fault. A sampling phase that drifts across a long packet shows up as corrupted bytes toward the end of it. A wrong state in the sync hunt shows up before any write: either a clean packet never produces pkt_done or a write, or a lone K produces no sync_err within the timeout. A miscounted buffer index becomes visible on the first write as an address that does not start at 0, or later as an overflow that fires one byte early or late.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    // Wire pair as {D+, D-}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA,
        ST_DRAIN
    } rx_state_e;

    // NRZI level carried by D-: J is high, K is low
    function automatic logic level_of(line_e ls);
        return ls[0];
    endfunction

    function automatic int min_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= RST_VAL[i];
                stable <= RST_VAL[i];
            end else begin
                meta   <= d_in[i];
                stable <= meta;
            end
        end
        assign q_out[i] = stable;
    end
endmodule

// File: rtl/usbrx_bittimer.sv
module usbrx_bittimer import usbrx_pkg::*; #(
    parameter int CLK_NUM = 32,
    parameter int CLK_DEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic align,
    input  logic run,
    output logic stb
);
    localparam int BASE = CLK_NUM / CLK_DEN;
    localparam int REM  = CLK_NUM % CLK_DEN;
    localparam int HALF = min_one(CLK_NUM / (2 * CLK_DEN));
    localparam int CW   = $clog2(BASE + 2);
    localparam int AW   = $clog2(CLK_DEN + 1);

    logic [CW-1:0] cnt;
    logic [AW-1:0] acc;
    logic [AW:0]   acc_sum;
    logic          leap;

    always_comb begin
        acc_sum = {1'b0, acc} + (AW+1)'(REM);
        leap    = (acc_sum >= (AW+1)'(CLK_DEN));
        stb     = run && !align && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            acc <= '0;
        end else if (align) begin
            cnt <= CW'(HALF - 1);
            acc <= '0;
        end else if (run) begin
            if (cnt == '0) begin
                if (leap) begin
                    cnt <= CW'(BASE);
                    acc <= AW'(acc_sum - (AW+1)'(CLK_DEN));
                end else begin
                    cnt <= CW'(BASE - 1);
                    acc <= AW'(acc_sum);
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/usbrx_unpack.sv
module usbrx_unpack (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       bit_stb,
    input  logic       level,
    output logic       byte_vld,
    output logic [7:0] byte_q,
    output logic [2:0] ones_run
);
    logic       prev_lvl;
    logic [2:0] nbits;
    logic       dbit;
    logic       stuffed;

    always_comb begin
        dbit    = (level == prev_lvl);
        stuffed = (ones_run == 3'd6);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_lvl <= 1'b0;
            ones_run <= '0;
            byte_q   <= '0;
            nbits    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (bit_stb) begin
                prev_lvl <= level;
                if (stuffed) begin
                    ones_run <= '0;
                end else begin
                    byte_q   <= {dbit, byte_q[7:1]};
                    ones_run <= dbit ? ones_run + 1'b1 : 3'd0;
                    nbits    <= nbits + 1'b1;
                    if (nbits == 3'd7) byte_vld <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx import usbrx_pkg::*; #(
    parameter int CLK_NUM       = 32,
    parameter int CLK_DEN       = 3,
    parameter int BUF_BYTES     = 11,
    parameter int SYNC_TMO_BITS = 3,
    localparam int ADDR_W = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
    localparam int CNT_W  = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dp_in,
    input  logic              dm_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              pkt_done,
    output logic              overflow,
    output logic              sync_err
);
    localparam int TMO_CLKS = min_one(SYNC_TMO_BITS * CLK_NUM / CLK_DEN);
    localparam int TW       = $clog2(TMO_CLKS + 1);

    logic [1:0] sync_q;
    line_e      line, prv_line;
    rx_state_e  state;
    logic       k_edge, align, run, stb;
    logic       samp_k, confirm, data_stb, eop;
    logic [TW-1:0] tmo;
    logic       byte_vld;
    logic [7:0] byte_q;
    logic [2:0] ones_run;

    usbrx_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({dp_in, dm_in}),
        .q_out (sync_q)
    );

    always_comb begin
        line     = line_e'(sync_q);
        k_edge   = (line == LS_K) && (prv_line == LS_J);
        align    = k_edge && (state == ST_IDLE || state == ST_HUNT);
        run      = (state == ST_HUNT) || (state == ST_DATA);
        confirm  = (state == ST_HUNT) && stb && (line == LS_K) && samp_k;
        data_stb = (state == ST_DATA) && stb && (line != LS_SE0);
        eop      = (state == ST_DATA) && stb && (line == LS_SE0);
    end

    usbrx_bittimer #(.CLK_NUM(CLK_NUM), .CLK_DEN(CLK_DEN)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .align (align),
        .run   (run),
        .stb   (stb)
    );

    usbrx_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .clear    (confirm),
        .bit_stb  (data_stb),
        .level    (level_of(line)),
        .byte_vld (byte_vld),
        .byte_q   (byte_q),
        .ones_run (ones_run)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            prv_line <= LS_J;
            samp_k   <= 1'b0;
            tmo      <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            byte_cnt <= '0;
            pkt_done <= 1'b0;
            overflow <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            prv_line <= line;
            wr_en    <= 1'b0;
            pkt_done <= 1'b0;
            overflow <= 1'b0;
            sync_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (k_edge) begin
                        state  <= ST_HUNT;
                        samp_k <= 1'b0;
                        tmo    <= '0;
                    end
                end
                ST_HUNT: begin
                    tmo <= k_edge ? '0 : tmo + 1'b1;
                    if (confirm) begin
                        state    <= ST_DATA;
                        byte_cnt <= '0;
                    end else begin
                        if (stb) samp_k <= (line == LS_K);
                        if (!k_edge && tmo == TW'(TMO_CLKS - 1)) begin
                            sync_err <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (eop) begin
                        pkt_done <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (byte_vld) begin
                        if (byte_cnt == CNT_W'(BUF_BYTES)) begin
                            overflow <= 1'b1;
                            state    <= ST_DRAIN;
                        end else begin
                            wr_en    <= 1'b1;
                            wr_addr  <= byte_cnt[ADDR_W-1:0];
                            wr_data  <= byte_q;
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (line == LS_SE0) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 4,
    parameter int BUF_BYTES = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic              pkt_done,
    input logic              overflow,
    input logic              sync_err,
    input logic [2:0]        ones_run
);
    p_cnt_follows_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(byte_cnt) == int'(wr_addr) + 1));

    p_cnt_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(byte_cnt) |-> (wr_en || byte_cnt == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < BUF_BYTES));

    p_ovf_full_r6: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (int'(byte_cnt) == BUF_BYTES));

    p_one_end_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pkt_done, overflow, sync_err}));

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !wr_en);

    p_no_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> !wr_en);

    p_run_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ones_run <= 3'd6);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .BUF_BYTES (BUF_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .byte_cnt (byte_cnt),
    .pkt_done (pkt_done),
    .overflow (overflow),
    .sync_err (sync_err),
    .ones_run (ones_run)
);

// File: tb/tb_usb_ls_rx.sv
module tb_usb_ls_rx;
    localparam int N   = 16;
    localparam int D   = 3;
    localparam int BUF = 4;
    localparam int TMO = 3;
    localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

    logic clk = 1'b0, rst = 1'b1, dp = 1'b0, dm = 1'b1;
    logic       wr_en, pkt_done, overflow, sync_err;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] byte_cnt;

    always #4 clk = ~clk;

    usb_ls_rx #(.CLK_NUM(N), .CLK_DEN(D), .BUF_BYTES(BUF), .SYNC_TMO_BITS(TMO)) dut (
        .clk(clk), .rst(rst), .dp_in(dp), .dm_in(dm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .byte_cnt(byte_cnt),
        .pkt_done(pkt_done), .overflow(overflow), .sync_err(sync_err)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] cap_d [0:15];
    int cap_a [0:15];
    int cap_n = 0, done_n = 0, ovf_n = 0, serr_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                if (cap_n < 16) begin
                    cap_d[cap_n] = wr_data;
                    cap_a[cap_n] = int'(wr_addr);
                end
                cap_n++;
            end
            if (pkt_done) done_n++;
            if (overflow) ovf_n++;
            if (sync_err) serr_n++;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; done_n = 0; ovf_n = 0; serr_n = 0;
    endtask

    int bidx;
    task automatic put(logic [1:0] ls);
        int dur;
        dur = ((bidx + 1) * N) / D - (bidx * N) / D;
        {dp, dm} = ls;
        repeat (dur) @(negedge clk);
        bidx++;
    endtask

    logic [7:0] pb [0:7];
    int pn = 0;
    int trail_n = 0;
    logic [7:0] trail = 8'h00;

    // Encoder built from R2 (sync order), R3 (NRZI), R4 (stuffing), R5 (EOP)
    task automatic send(int extra_pairs);
        logic lvl;
        logic d;
        int ones;
        bidx = 0;
        @(negedge clk);
        repeat (extra_pairs) begin put(LK); put(LJ); end
        put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LJ); put(LK); put(LK);
        lvl = 1'b0; ones = 0;
        for (int i = 0; i < pn * 8 + trail_n; i++) begin
            d = (i < pn * 8) ? pb[i / 8][i % 8] : trail[i - pn * 8];
            if (d) ones++; else ones = 0;
            if (!d) lvl = ~lvl;
            put(lvl ? LJ : LK);
            if (ones == 6) begin
                lvl = ~lvl;
                put(lvl ? LJ : LK);
                ones = 0;
            end
        end
        put(LSE0); put(LSE0); put(LJ);
        repeat (12) @(negedge clk);
    endtask

    task automatic check_packet(string tag);
        check(done_n == 1, {tag, " R5 done pulses"}, done_n, 1);
        check(cap_n == pn, {tag, " R9 write count"}, cap_n, pn);
        check(int'(byte_cnt) == pn, {tag, " R9 byte_cnt"}, int'(byte_cnt), pn);
        check(ovf_n == 0 && serr_n == 0, {tag, " R6/R7 spurious error"}, ovf_n + serr_n, 0);
        for (int i = 0; i < pn && i < cap_n; i++) begin
            check(cap_d[i] == pb[i], {tag, " R3 data"}, int'(cap_d[i]), int'(pb[i]));
            check(cap_a[i] == i, {tag, " R9 address"}, cap_a[i], i);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!wr_en && !pkt_done && !overflow && !sync_err, "R1 strobes after reset",
              int'({wr_en, pkt_done, overflow, sync_err}), 0);
        check(byte_cnt == 3'd0, "R1 byte_cnt after reset", int'(byte_cnt), 0);
        repeat (40) @(negedge clk);
        check(cap_n + done_n + ovf_n + serr_n == 0, "R1 idle J silent",
              cap_n + done_n + ovf_n + serr_n, 0);

        // R3: basic packet
        clear_cap(); pb[0] = 8'hA5; pb[1] = 8'h3C; pn = 2; trail_n = 0;
        send(0); check_packet("R3 basic");

        // R4: long runs of ones, stuffing inside and across bytes
        clear_cap(); pb[0] = 8'h3F; pb[1] = 8'hFE; pb[2] = 8'hFF; pb[3] = 8'hFF; pn = 4;
        send(0); check_packet("R4 stuffing");

        // R2: extra K,J pairs ahead of the closing K,K
        clear_cap(); pb[0] = 8'h81; pn = 1;
        send(3); check_packet("R2 long sync");

        // R5: trailing partial byte dropped
        clear_cap(); pb[0] = 8'h00; pb[1] = 8'h7E; pn = 2; trail_n = 3; trail = 8'h05;
        send(0); check_packet("R5 partial");
        trail_n = 0;

        // R6: one byte too many, then a clean packet to show the tail was ignored
        clear_cap();
        for (int i = 0; i < 5; i++) pb[i] = 8'(8'h11 * (i + 1));
        pn = 5;
        send(0);
        check(cap_n == BUF, "R6 writes before abort", cap_n, BUF);
        check(ovf_n == 1, "R6 overflow pulse", ovf_n, 1);
        check(done_n == 0, "R6 no done after abort", done_n, 0);
        check(int'(byte_cnt) == BUF, "R6 byte_cnt held", int'(byte_cnt), BUF);
        clear_cap(); pb[0] = 8'hC3; pn = 1;
        send(0); check_packet("R6 after drain");

        // R7: lone K then idle J
        clear_cap(); bidx = 0;
        @(negedge clk);
        put(LK); {dp, dm} = LJ;
        repeat (TMO * N / D + 20) @(negedge clk);
        check(serr_n == 1, "R7 sync_err pulse", serr_n, 1);
        check(cap_n == 0 && done_n == 0, "R7 no writes", cap_n + done_n, 0);
        clear_cap(); pb[0] = 8'h5A; pn = 1;
        send(0); check_packet("R7 recovery");

        // R8: sweep every byte value through the fractional schedule
        for (int v = 0; v < 256; v++) begin
            clear_cap();
            pb[0] = 8'(v); pb[1] = 8'hFF; pb[2] = 8'(v) ^ 8'h5A; pn = 3;
            send(v % 3);
            check_packet("R8 sweep");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule